// File: doc/BRIEF.md
# Configurable Pixel Format Packer

This block takes a stream of 32-bit pixels, each carrying 8-bit alpha, red, green and blue channels, and repacks every pixel into one of twelve memory layouts before it goes to a write engine. A 4-bit format code chooses the bit depth (4444, 565, 888 or 8888) and the channel order. The packer also applies an alpha policy: pass the pixel's alpha through, invert it, or replace it with a constant. It gates the byte lanes of the packed word with a 4-bit enable mask.

The input pixel carries its control fields alongside it and moves on a valid/ready handshake. The output is a registered word with a per-byte strobe, the number of bytes the pixel occupies, and an error flag for format codes that have no meaning. The output stage respects backpressure and never drops or repeats a pixel. Dithering, rotation, tiled layouts and the memory write itself belong to other blocks.

Top module: `pfp_packer`

## Requirements
- R1: While reset is held and right after it, `out_valid` is 0, `out_strb` is 0 and `in_ready` is 1.
- R2: Codes 0..3 pack 16-bit pixels into `out_data[15:0]`, with the channel orders A-B-G-R, A-R-G-B, B-G-R-A and R-G-B-A from the most significant nibble down. Each channel is cut to its top 4 bits. `out_data[31:16]` is 0. Input byte order is A=`in_pixel[31:24]`, R=`[23:16]`, G=`[15:8]` and B=`[7:0]`.
- R3: Code 6 packs B5-G6-R5 and code 7 packs R5-G6-B5 into `out_data[15:0]`, using the top bits of each channel. The alpha controls have no effect on these codes.
- R4: Code 8 packs B-G-R and code 9 packs R-G-B into `out_data[23:0]`, with the first channel in the top byte. `out_data[31:24]` is 0.
- R5: Codes 12..15 pack A-B-G-R, A-R-G-B, B-G-R-A and R-G-B-A as full bytes from `out_data[31:24]` down.
- R6: With `in_alpha_en`=1, the alpha field holds the pixel's alpha, bitwise inverted when `in_alpha_inv`=1.
- R7: With `in_alpha_en`=0, the alpha field is all ones when `in_alpha_inv`=0 and all zeros when `in_alpha_inv`=1.
- R8: `out_count` is 2 for codes 0..3, 6 and 7, 3 for codes 8 and 9, and 4 for codes 12..15. `out_strb[i]` (the byte `out_data[8i+7:8i]`) is 1 only when lane i lies below `out_count` and `in_byte_en[i]`=1. The mask does not change `out_data`.
- R9: Codes 4, 5, 10 and 11 give `out_err`=1, `out_count`=0, `out_strb`=0 and `out_data`=0. Every other code gives `out_err`=0.
- R10: A pixel accepted at a clock edge (`in_valid` and `in_ready` both 1) appears on the outputs with `out_valid`=1 right after that edge. `in_ready` is 1 whenever the output register is empty or being drained. Back-to-back pixels pass at one per cycle.
- R11: While `out_valid`=1 and `out_ready`=0, all outputs hold and `in_ready` is 0. No pixel is lost or repeated once the stall ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Packer can take a pixel |
| in_pixel | input | 32 | A, R, G, B bytes, high to low |
| in_fmt | input | 4 | Output format code |
| in_alpha_en | input | 1 | Keep pixel alpha |
| in_alpha_inv | input | 1 | Invert alpha, or select the fill value |
| in_byte_en | input | 4 | Byte lane enable mask |
| out_valid | output | 1 | Packed word valid |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | 32 | Packed pixel, low-aligned |
| out_strb | output | 4 | Per-byte write strobe |
| out_count | output | 3 | Bytes in the packed pixel (0 on error) |
| out_err | output | 1 | Unused format code |

## Verification
Some properties are checked on every cycle. The output holds while stalled. An accepted pixel shows up on the next cycle. Error codes carry no strobe and no count. Strobes never reach above the byte count. Both 16-bit classes leave the upper half zero. The 8888 class always reports four bytes. Only the bench's scenarios can show the exact channel order, the truncation, the alpha policies and the masking of each format. They also show that a stalled pixel and its successor both come out, once and in order.

// File: rtl/pfp_pkg.sv
package pfp_pkg;

   typedef enum logic [2:0] {
      DEP_4444,
      DEP_565,
      DEP_888,
      DEP_8888,
      DEP_NONE
   } depth_e;

   // channel identifiers equal the byte position inside the input pixel
   typedef logic [1:0] chan_id_t;
   localparam chan_id_t CH_B = 2'd0;
   localparam chan_id_t CH_G = 2'd1;
   localparam chan_id_t CH_R = 2'd2;
   localparam chan_id_t CH_A = 2'd3;

   // slot[3] is the most significant field, slot[0] the least
   typedef struct packed {
      depth_e             depth;
      chan_id_t [3:0]     slot;
   } layout_t;

endpackage

// File: rtl/pfp_decode.sv
module pfp_decode
   import pfp_pkg::*;
(
   input  logic [3:0] fmt,
   output layout_t    lay
);

   always_comb begin
      lay.depth = DEP_NONE;
      lay.slot  = {CH_A, CH_R, CH_G, CH_B};
      unique case (fmt[3:2])
         2'b00, 2'b11: begin
            lay.depth = (fmt[3]) ? DEP_8888 : DEP_4444;
            unique case (fmt[1:0])
               2'd0: lay.slot = {CH_A, CH_B, CH_G, CH_R};
               2'd1: lay.slot = {CH_A, CH_R, CH_G, CH_B};
               2'd2: lay.slot = {CH_B, CH_G, CH_R, CH_A};
               default: lay.slot = {CH_R, CH_G, CH_B, CH_A};
            endcase
         end
         2'b01, 2'b10: begin
            // 565 lives at 6/7, 888 at 8/9; the other codes are unused
            if (fmt[1] == fmt[3]) lay.depth = DEP_NONE;
            else lay.depth = (fmt[3]) ? DEP_888 : DEP_565;
            lay.slot = (fmt[0]) ? {CH_A, CH_R, CH_G, CH_B}
                                : {CH_A, CH_B, CH_G, CH_R};
         end
         default: lay.depth = DEP_NONE;
      endcase
   end

endmodule

// File: rtl/pfp_alpha.sv
module pfp_alpha #(
   parameter int LANE_W = 8
) (
   input  logic [LANE_W-1:0] a_in,
   input  logic              keep,
   input  logic              invert,
   output logic [LANE_W-1:0] a_out
);

   always_comb begin
      if (keep) a_out = invert ? ~a_in : a_in;
      else      a_out = {LANE_W{~invert}};
   end

endmodule

// File: rtl/pfp_pack.sv
module pfp_pack
   import pfp_pkg::*;
#(
   parameter int LANE_W = 8,
   parameter int LANES  = 4,
   parameter int CNT_W  = 3
) (
   input  logic [LANES-1:0][LANE_W-1:0] chan,
   input  layout_t                      lay,
   output logic [LANES*LANE_W-1:0]      data,
   output logic [LANES-1:0]             lanes,
   output logic [CNT_W-1:0]             count
);

   localparam int PIX_W = LANES * LANE_W;
   localparam int HALF  = PIX_W / 2;

   logic [LANES-1:0][LANE_W-1:0] sel;

   for (genvar i = 0; i < LANES; i++) begin : g_sel
      assign sel[i] = chan[lay.slot[i]];
   end

   always_comb begin
      data  = '0;
      lanes = '0;
      count = '0;
      unique case (lay.depth)
         DEP_4444: begin
            data  = {{HALF{1'b0}}, sel[3][LANE_W-1 -: 4], sel[2][LANE_W-1 -: 4],
                     sel[1][LANE_W-1 -: 4], sel[0][LANE_W-1 -: 4]};
            lanes = LANES'(4'b0011);
            count = CNT_W'(2);
         end
         DEP_565: begin
            data  = {{HALF{1'b0}}, sel[2][LANE_W-1 -: 5], sel[1][LANE_W-1 -: 6],
                     sel[0][LANE_W-1 -: 5]};
            lanes = LANES'(4'b0011);
            count = CNT_W'(2);
         end
         DEP_888: begin
            data  = {{LANE_W{1'b0}}, sel[2], sel[1], sel[0]};
            lanes = LANES'(4'b0111);
            count = CNT_W'(3);
         end
         DEP_8888: begin
            data  = {sel[3], sel[2], sel[1], sel[0]};
            lanes = LANES'(4'b1111);
            count = CNT_W'(4);
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/pfp_packer.sv
module pfp_packer
   import pfp_pkg::*;
#(
   parameter int LANE_W = 8,
   parameter int LANES  = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   output logic                     in_ready,
   input  logic [LANES*LANE_W-1:0]  in_pixel,
   input  logic [3:0]               in_fmt,
   input  logic                     in_alpha_en,
   input  logic                     in_alpha_inv,
   input  logic [LANES-1:0]         in_byte_en,
   output logic                     out_valid,
   input  logic                     out_ready,
   output logic [LANES*LANE_W-1:0]  out_data,
   output logic [LANES-1:0]         out_strb,
   output logic [2:0]               out_count,
   output logic                     out_err
);

   localparam int PIX_W = LANES * LANE_W;
   localparam int CNT_W = $clog2(LANES + 1);

   if (LANE_W != 8) begin : g_bad_lane
      $error("pfp_packer: formats are defined on 8-bit channels");
   end
   if (LANES != 4) begin : g_bad_lanes
      $error("pfp_packer: formats are defined on four channels");
   end
   if (CNT_W != 3) begin : g_bad_cnt
      $error("pfp_packer: count width must be 3");
   end

   layout_t                      lay;
   logic [LANE_W-1:0]            alpha_q;
   logic [LANES-1:0][LANE_W-1:0] chan;
   logic [PIX_W-1:0]             data_c;
   logic [LANES-1:0]             lanes_c;
   logic [LANES-1:0]             strb_c;
   logic [CNT_W-1:0]             count_c;
   logic                         load;

   pfp_decode u_decode (
      .fmt (in_fmt),
      .lay (lay)
   );

   pfp_alpha #(.LANE_W(LANE_W)) u_alpha (
      .a_in   (in_pixel[PIX_W-1 -: LANE_W]),
      .keep   (in_alpha_en),
      .invert (in_alpha_inv),
      .a_out  (alpha_q)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_chan
      if (i == int'(CH_A)) begin : g_alpha
         assign chan[i] = alpha_q;
      end else begin : g_color
         assign chan[i] = in_pixel[i*LANE_W +: LANE_W];
      end
   end

   pfp_pack #(.LANE_W(LANE_W), .LANES(LANES), .CNT_W(CNT_W)) u_pack (
      .chan  (chan),
      .lay   (lay),
      .data  (data_c),
      .lanes (lanes_c),
      .count (count_c)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_strb
      assign strb_c[i] = lanes_c[i] & in_byte_en[i];
   end

   assign in_ready = !out_valid || out_ready;
   assign load     = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_strb  <= '0;
         out_count <= '0;
         out_err   <= 1'b0;
      end else if (load) begin
         out_valid <= 1'b1;
         out_data  <= data_c;
         out_strb  <= strb_c;
         out_count <= count_c;
         out_err   <= (lay.depth == DEP_NONE);
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_strb)
                                     && $stable(out_count) && $stable(out_err))); // R11
   AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid); // R10
   AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_err) |-> (out_strb == '0 && out_count == '0)); // R9
   AST_STRB_IN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_err) |-> ((out_strb >> out_count) == '0)); // R8
   AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_count == 3'd2) |-> (out_data[PIX_W-1:PIX_W/2] == '0)); // R2
   AST_WIDE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_fmt[3:2] == 2'b11) |=> (out_count == 3'd4)); // R5

endmodule

// File: tb/pfp_packer_bench.sv
module pfp_packer_bench;

   typedef struct packed {
      logic [3:0]  fmt;
      logic        aen;
      logic        ainv;
      logic [3:0]  ben;
      logic [31:0] pix;
      logic [31:0] edat;
      logic [3:0]  estb;
      logic [2:0]  ecnt;
      logic        eerr;
      logic [3:0]  req;
   } vec_t;

   localparam logic [31:0] P = 32'hA1B2C3D4;
   localparam logic [31:0] Q = 32'h0F7E8C19;
   localparam int NV = 25;
   localparam vec_t VEC [NV] = '{
      // R2 4444 orders, R6/R7 alpha policies
      '{4'd0,  1'b1, 1'b0, 4'hF, P, 32'h0000ADCB, 4'h3, 3'd2, 1'b0, 4'd2},
      '{4'd1,  1'b1, 1'b0, 4'hF, P, 32'h0000ABCD, 4'h3, 3'd2, 1'b0, 4'd2},
      '{4'd1,  1'b1, 1'b0, 4'hF, Q, 32'h00000781, 4'h3, 3'd2, 1'b0, 4'd2},
      '{4'd2,  1'b1, 1'b1, 4'hF, P, 32'h0000DCB5, 4'h3, 3'd2, 1'b0, 4'd6},
      '{4'd3,  1'b0, 1'b0, 4'hF, P, 32'h0000BCDF, 4'h3, 3'd2, 1'b0, 4'd7},
      '{4'd0,  1'b0, 1'b1, 4'hF, P, 32'h00000DCB, 4'h3, 3'd2, 1'b0, 4'd7},
      // R3 565
      '{4'd7,  1'b1, 1'b0, 4'hF, P, 32'h0000B61A, 4'h3, 3'd2, 1'b0, 4'd3},
      '{4'd6,  1'b1, 1'b0, 4'hF, P, 32'h0000D616, 4'h3, 3'd2, 1'b0, 4'd3},
      '{4'd7,  1'b0, 1'b1, 4'hF, P, 32'h0000B61A, 4'h3, 3'd2, 1'b0, 4'd3},
      '{4'd7,  1'b1, 1'b0, 4'hF, Q, 32'h00007C63, 4'h3, 3'd2, 1'b0, 4'd3},
      // R4 888
      '{4'd9,  1'b1, 1'b0, 4'hF, P, 32'h00B2C3D4, 4'h7, 3'd3, 1'b0, 4'd4},
      '{4'd8,  1'b0, 1'b1, 4'hF, P, 32'h00D4C3B2, 4'h7, 3'd3, 1'b0, 4'd4},
      // R5 8888 with R6/R7 alpha
      '{4'd13, 1'b1, 1'b0, 4'hF, P, 32'hA1B2C3D4, 4'hF, 3'd4, 1'b0, 4'd5},
      '{4'd12, 1'b1, 1'b1, 4'hF, P, 32'h5ED4C3B2, 4'hF, 3'd4, 1'b0, 4'd6},
      '{4'd14, 1'b0, 1'b0, 4'hF, P, 32'hD4C3B2FF, 4'hF, 3'd4, 1'b0, 4'd7},
      '{4'd15, 1'b0, 1'b1, 4'hF, P, 32'hB2C3D400, 4'hF, 3'd4, 1'b0, 4'd7},
      '{4'd13, 1'b1, 1'b0, 4'hF, Q, 32'h0F7E8C19, 4'hF, 3'd4, 1'b0, 4'd5},
      // R8 byte masks
      '{4'd15, 1'b1, 1'b0, 4'h5, P, 32'hB2C3D4A1, 4'h5, 3'd4, 1'b0, 4'd8},
      '{4'd9,  1'b1, 1'b0, 4'hA, P, 32'h00B2C3D4, 4'h2, 3'd3, 1'b0, 4'd8},
      '{4'd1,  1'b1, 1'b0, 4'hE, P, 32'h0000ABCD, 4'h2, 3'd2, 1'b0, 4'd8},
      '{4'd13, 1'b1, 1'b0, 4'h0, P, 32'hA1B2C3D4, 4'h0, 3'd4, 1'b0, 4'd8},
      // R9 unused codes
      '{4'd4,  1'b1, 1'b0, 4'hF, P, 32'h00000000, 4'h0, 3'd0, 1'b1, 4'd9},
      '{4'd5,  1'b0, 1'b1, 4'hF, P, 32'h00000000, 4'h0, 3'd0, 1'b1, 4'd9},
      '{4'd10, 1'b1, 1'b1, 4'hF, P, 32'h00000000, 4'h0, 3'd0, 1'b1, 4'd9},
      '{4'd11, 1'b0, 1'b0, 4'hF, P, 32'h00000000, 4'h0, 3'd0, 1'b1, 4'd9}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_pixel = '0;
   logic [3:0]  in_fmt = '0;
   logic        in_alpha_en = 1'b0;
   logic        in_alpha_inv = 1'b0;
   logic [3:0]  in_byte_en = 4'hF;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [31:0] out_data;
   logic [3:0]  out_strb;
   logic [2:0]  out_count;
   logic        out_err;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   pfp_packer u_pfp_packer (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .in_ready     (in_ready),
      .in_pixel     (in_pixel),
      .in_fmt       (in_fmt),
      .in_alpha_en  (in_alpha_en),
      .in_alpha_inv (in_alpha_inv),
      .in_byte_en   (in_byte_en),
      .out_valid    (out_valid),
      .out_ready    (out_ready),
      .out_data     (out_data),
      .out_strb     (out_strb),
      .out_count    (out_count),
      .out_err      (out_err)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [3:0] f, input logic ae, input logic ai,
                        input logic [3:0] be, input logic [31:0] px);
      in_fmt = f; in_alpha_en = ae; in_alpha_inv = ai; in_byte_en = be; in_pixel = px;
      in_valid = 1'b1;
   endtask

   initial begin
      #800000;
      errors++;
      checks++;
      $display("FAIL R10 watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      check("R1 in reset", {61'd0, out_valid, in_ready, |out_strb}, {61'd0, 1'b0, 1'b1, 1'b0});
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", {61'd0, out_valid, in_ready, |out_strb}, {61'd0, 1'b0, 1'b1, 1'b0});

      // table walk: R2..R9
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VEC[i].fmt, VEC[i].aen, VEC[i].ainv, VEC[i].ben, VEC[i].pix);
         @(negedge clk);
         in_valid = 1'b0;
         check($sformatf("R%0d vector %0d", VEC[i].req, i),
               {23'd0, out_valid, out_data, out_strb, out_count, out_err},
               {23'd0, 1'b1, VEC[i].edat, VEC[i].estb, VEC[i].ecnt, VEC[i].eerr});
      end

      // R10 back-to-back streaming, one per cycle
      @(negedge clk);
      drive(4'd13, 1'b1, 1'b0, 4'hF, 32'h01020304);
      @(negedge clk);
      check("R10 stream 0", {31'd0, out_valid, out_data}, {31'd0, 1'b1, 32'h01020304});
      drive(4'd13, 1'b1, 1'b0, 4'hF, 32'h05060708);
      @(negedge clk);
      check("R10 stream 1", {31'd0, out_valid, out_data}, {31'd0, 1'b1, 32'h05060708});
      in_valid = 1'b0;
      @(negedge clk);
      check("R10 drain", {63'd0, out_valid}, 64'd0);

      // R11 backpressure
      out_ready = 1'b0;
      drive(4'd13, 1'b1, 1'b0, 4'hF, 32'h11111111);
      @(negedge clk);
      check("R11 first loaded", {30'd0, out_valid, in_ready, out_data},
            {30'd0, 1'b1, 1'b0, 32'h11111111});
      drive(4'd9, 1'b1, 1'b0, 4'hF, 32'h22222222);
      repeat (3) @(negedge clk);
      check("R11 held", {26'd0, out_valid, in_ready, out_data, out_strb},
            {26'd0, 1'b1, 1'b0, 32'h11111111, 4'hF});
      out_ready = 1'b1;
      @(negedge clk);
      check("R11 successor", {27'd0, out_valid, out_data, out_count},
            {27'd0, 1'b1, 32'h00222222, 3'd3});
      in_valid = 1'b0;
      @(negedge clk);
      check("R11 no repeat", {63'd0, out_valid}, 64'd0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule